// File: doc/BRIEF.md
# Lockstep Pairwise Vector Summation Unit

This block adds up the N signed elements of a short vector with a row of identical lanes. One sequencer drives every lane with the same control word, so all lanes act in lockstep. Each lane holds a partial sum, and on each clock every active lane adds the partial sum held by one partner lane. After log2(N) clocks the full total sits in lane 0.

The caller presents all N operands in parallel and pulses `start`. The `halfMode` input picks the partner order. When it is low, neighbours combine first and the stride doubles on each step. When it is high, lanes half the vector apart combine first and the stride halves on each step. Both orders give the same total. Every lane's partial sum is brought out on `laneSums` so the reduction can be watched one step at a time.

Top module: `lane_sum_reducer`

## Requirements
- R1: For N lanes, `done` rises exactly log2(N)+1 rising edges after the edge that accepts `start`. The accepting edge is the first of these edges, and each of the log2(N) edges that follow performs one reduction step.
- R2: With `halfMode`=0, step s (counting from 0) uses stride 2^s. Every lane i with i mod 2^(s+1) = 0 adds the sum held by lane i+2^s. For N=8 this means lanes 0,2,4,6, then lanes 0,4, then lane 0.
- R3: With `halfMode`=1, step s uses stride N/2^(s+1). Every lane i below that stride adds the sum held by lane i+stride. For N=8 this means lanes 0..3 with partner i+4, then lanes 0,1 with partner i+2, then lane 0 with partner lane 1.
- R4: The edge that accepts `start` loads every lane with its operand, sign-extended. Operand i sits in `operands` bits [i*W+W-1 : i*W].
- R5: A lane that is not active in a step keeps its partial sum unchanged.
- R6: `done` is high for exactly one cycle. In that cycle `total` (lane 0) equals the signed sum of the operands that were loaded.
- R7: A `start` that arrives while a reduction is in progress is ignored. No lane is reloaded, and the running reduction finishes with its original total.
- R8: Partial sums are W+log2(N) bits wide, so no operand values can overflow them. Both partner orders give the same total for the same operands.
- R9: After reset, `done` is low and every lane holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load operands and begin a reduction (accepted only when idle) |
| halfMode | input | 1 | Partner order: 0 = stride doubling, 1 = stride halving |
| operands | input | N*W | N signed operands, lane i in bits [i*W +: W] |
| total | output | W+log2(N) | Reduced total (lane 0), valid while done is high |
| done | output | 1 | One-cycle completion pulse |
| laneSums | output | N*(W+log2(N)) | Per-lane partial sums for debug, lane i in bits [i*(W+log2(N)) +: W+log2(N)] |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of a reduction. The bench raises `start` with a different operand vector on the clock just after the load, so the pulse falls inside the first step. It then checks each lane's partial sum on every step, as well as the final total, against the original vector. Lane activity for each step is covered by comparing all lanes after every step in both orders. The inactive lanes must hold their values, which is confirmed by that same comparison. The bench also drives all-minimum and all-maximum vectors to reach the widest sums.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef struct packed {
    logic       load;
    logic       stepEn;
    logic [4:0] stepIdx;
    logic       halfMode;
  } lsrCtrl_t;
endpackage

// File: rtl/lsr_seq.sv
module lsr_seq
  import lsr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     modeIn,
  output lsrCtrl_t ctl,
  output logic     done
);
  localparam int LOGN = $clog2(N);
  localparam logic [4:0] LAST_STEP = 5'(LOGN - 1);

  logic       busy;
  logic [4:0] stepCnt;
  logic       modeReg;

  always_comb begin
    ctl.load     = start && !busy;
    ctl.stepEn   = busy;
    ctl.stepIdx  = stepCnt;
    ctl.halfMode = modeReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      modeReg <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
        modeReg <= modeIn;
      end else if (busy) begin
        if (stepCnt == LAST_STEP) begin
          busy    <= 1'b0;
          stepCnt <= '0;
          done    <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 5'd1;
        end
      end
    end
  end

  AST_LOAD_THEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (ctl.stepEn && ctl.stepIdx == 5'd0)); // R4
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepEn && ctl.stepIdx != LAST_STEP) |=> (ctl.stepEn && ctl.stepIdx == $past(ctl.stepIdx) + 5'd1)); // R1
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepEn && ctl.stepIdx == LAST_STEP) |=> done); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepEn |-> !ctl.load); // R7
endmodule

// File: rtl/lsr_lanes.sv
module lsr_lanes
  import lsr_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  lsrCtrl_t        ctl,
  input  logic [N*W-1:0]  operands,
  output logic [N*(W+$clog2(N))-1:0] sums
);
  localparam int LOGN = $clog2(N);
  localparam int SW   = W + LOGN;

  logic signed [SW-1:0] sumReg [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic                 act;
    logic signed [SW-1:0] partner;
    logic        [W-1:0]  opSlice;

    assign opSlice = operands[i*W +: W];

    always_comb begin
      act     = 1'b0;
      partner = '0;
      for (int k = 0; k < LOGN; k++) begin
        if (int'(ctl.stepIdx) == k) begin
          if (ctl.halfMode) begin
            if (i < (N >> (k + 1))) begin
              act     = 1'b1;
              partner = sumReg[LOGN'((i + (N >> (k + 1))) % N)];
            end
          end else if ((i % (2 << k)) == 0) begin
            act     = 1'b1;
            partner = sumReg[LOGN'((i + (1 << k)) % N)];
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        sumReg[i] <= '0;
      else if (ctl.load)
        sumReg[i] <= {{LOGN{opSlice[W-1]}}, opSlice};
      else if (ctl.stepEn && act)
        sumReg[i] <= sumReg[i] + partner;
    end

    assign sums[i*SW +: SW] = sumReg[i];

    AST_IDLE_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.stepEn && !act) |=> $stable(sumReg[i])); // R5
  end

  AST_TOP_LANE_ONLY_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(sumReg[N-1])); // R5
endmodule

// File: rtl/lane_sum_reducer.sv
module lane_sum_reducer
  import lsr_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          halfMode,
  input  logic [N*W-1:0]                operands,
  output logic [W+$clog2(N)-1:0]        total,
  output logic                          done,
  output logic [N*(W+$clog2(N))-1:0]    laneSums
);
  localparam int SW = W + $clog2(N);

  lsrCtrl_t ctl;

  lsr_seq #(.N(N)) u_seq (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(halfMode),
    .ctl(ctl), .done(done)
  );

  lsr_lanes #(.N(N), .W(W)) u_lanes (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operands(operands), .sums(laneSums)
  );

  assign total = laneSums[SW-1:0];

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ctl.stepEn); // R6
endmodule

// File: tb/sim_lane_sum_reducer.sv
module sim_lane_sum_reducer;
  localparam int N    = 8;
  localparam int W    = 8;
  localparam int LOGN = $clog2(N);
  localparam int SW   = W + LOGN;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic               halfMode = 1'b0;
  logic [N*W-1:0]     operands = '0;
  logic [SW-1:0]      total;
  logic               done;
  logic [N*SW-1:0]    laneSums;

  int total_checks = 0;
  int bad_checks = 0;
  int model [N];

  always #4 clk = ~clk;

  lane_sum_reducer #(.N(N), .W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .halfMode(halfMode),
    .operands(operands), .total(total), .done(done), .laneSums(laneSums)
  );

  task automatic check(input string req, input int act, input int exp);
    total_checks++;
    if (act != exp) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int laneVal(input int i);
    return int'($signed(laneSums[i*SW +: SW]));
  endfunction

  task automatic modelStep(input bit hm, input int s);
    if (hm) begin
      int stride = N >> (s + 1);
      for (int i = 0; i < stride; i++) model[i] += model[i + stride];
    end else begin
      int stride = 1 << s;
      for (int i = 0; i < N; i += 2 * stride) model[i] += model[i + stride];
    end
  endtask

  task automatic runVec(input bit hm, input logic [N*W-1:0] vec, input bit busyPoke);
    int expSum = 0;
    for (int i = 0; i < N; i++) begin
      model[i] = int'($signed(vec[i*W +: W]));
      expSum += model[i];
    end
    @(negedge clk);
    start = 1'b1; halfMode = hm; operands = vec;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) check("R4 load", laneVal(i), model[i]);
    check("R1 no early done", int'(done), 0);
    if (busyPoke) begin
      start = 1'b1; halfMode = ~hm; operands = ~vec;
    end
    for (int s = 0; s < LOGN; s++) begin
      modelStep(hm, s);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < N; i++)
        check(hm ? "R3 R5 halving step" : "R2 R5 doubling step", laneVal(i), model[i]);
      if (s != LOGN - 1) check("R1 done timing", int'(done), 0);
    end
    check("R1 R6 done pulse", int'(done), 1);
    check(busyPoke ? "R7 total after busy start" : "R6 R8 total", int'($signed(total)), expSum);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    if (busyPoke) check("R7 no reload", laneVal(N - 1), model[N - 1]);
  endtask

  initial begin
    #(8 * 150000);
    bad_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    logic [N*W-1:0] v;
    repeat (3) @(negedge clk);
    check("R9 reset done", int'(done), 0);
    for (int i = 0; i < N; i++) check("R9 reset lanes", laneVal(i), 0);
    rstN = 1'b1;

    for (int m = 0; m < 2; m++) begin
      v = '0;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
      runVec(bit'(m), v, 1'b0);
      for (int i = 0; i < N; i++) v[i*W +: W] = {1'b1, {(W-1){1'b0}}};
      runVec(bit'(m), v, 1'b0);   // R8 most negative
      for (int i = 0; i < N; i++) v[i*W +: W] = {1'b0, {(W-1){1'b1}}};
      runVec(bit'(m), v, 1'b0);   // R8 most positive
      for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? W'(-3) : W'(5);
      runVec(bit'(m), v, 1'b1);   // R7 start while busy
    end

    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
      runVec(1'b0, v, 1'b0);
      runVec(1'b1, v, n % 7 == 0);  // R8 same vector both orders
    end

    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule